// File: doc/BRIEF.md
# JTAG Debug Port Scan Chain

This block is the target side of a JTAG debug port. It contains the sixteen-state TAP controller, a 4-bit instruction register, and the data registers that the instruction register selects. Those registers are a one-bit bypass, a fixed 32-bit identification word, two 35-bit access registers and an abort register. The access registers carry requests in two directions during one scan. The bits that go in hold a request for either the debug-port register group or the access-port register group. The bits that come out hold the read data and acknowledge of the previous request.

A debugger drives TCK, TMS and TDI and reads TDO. On the target side, an Update-DR of an access scan produces a one-cycle strobe on a parallel request port. The strobe carries the write data, the 2-bit register address, the read/write flag and the register group. The logic behind the request port returns read data and a 3-bit acknowledge on the response inputs. The next Capture-DR samples them. An abort scan produces a one-cycle abort pulse instead of a request.

All logic runs on TCK. TRST is active low and acts synchronously on TCK edges.

Top module: `jtag_dap_top`

## Requirements
- R1: While trst_n is low at a rising TCK edge, or after five rising edges with TMS high, the controller is in Test-Logic-Reset and the instruction becomes 1110. A DR scan that follows without a new instruction returns the identification word.
- R2: Capture-IR loads 0001 into the instruction shift path. The shift path is shifted out least significant bit first.
- R3: Instruction 1110 selects a 32-bit register that captures 0x3BA00477: version 0x3 in bits 31:28, part 0xBA00 in bits 27:12, manufacturer 0x23B in bits 11:1, and bit 0 = 1.
- R4: The instruction codes are 1111 bypass, 1110 identification, 1010 debug-port access, 1011 access-port access and 1000 abort. Every other code selects the one-bit bypass register. The bypass register captures 0 and delays TDI by one TCK cycle.
- R5: An access scan (1010 or 1011) is 35 bits long. Capture-DR loads rsp_data into scan bits 34:3 and rsp_ack into scan bits 2:0, and these bits are shifted out LSB first. The acknowledge passes through unchanged: 001 = wait, 010 = ok/fault.
- R6: Update-DR of an access scan raises req_valid for exactly one TCK cycle. At the same time it presents these fields:
  - req_wdata = scan bits 34:3
  - req_addr = scan bits 2:1 (debug-port group: 00 reserved, 01 control/status, 10 select, 11 read buffer)
  - req_rnw = scan bit 0 (1 = read)
  - req_ap = 1 for 1011 and 0 for 1010
- R7: The abort scan is 35 bits long and captures zero. At Update-DR, abort_pulse is high for one TCK cycle exactly when scan bit 3 (data bit 0) is 1. The other bits have no effect. An abort scan never raises req_valid.
- R8: tdo_oe is high only while the controller is in Shift-IR or Shift-DR. tdo and tdo_oe change only on falling TCK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising TCK |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO drive enable |
| rsp_data | input | 32 | Read data of the previous request |
| rsp_ack | input | 3 | Acknowledge of the previous request |
| req_valid | output | 1 | One-cycle request strobe |
| req_ap | output | 1 | 1 = access-port group, 0 = debug-port group |
| req_addr | output | 2 | Register address A[3:2] |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_wdata | output | 32 | Write data |
| abort_pulse | output | 1 | One-cycle abort pulse |

## Verification
On every TCK edge of an access scan, the same shift path carries two things in opposite directions. It delivers one captured response bit to TDO and takes in one request bit from TDI. The bench provokes this in two ways:
- It sweeps all sixteen instruction codes, with two opposite TDI patterns each.
- For every code it loads a response word and acknowledge that depend on the code.

For each scan the bench computes two expected results arithmetically: the 40-bit TDO stream, built from the selected register's length and capture value, and the request fields left in the register when Update-DR occurs. Both must match in the same scan.

// File: rtl/dap_pkg.sv
package dap_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] INS_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] INS_IDENT  = 4'b1110;
  localparam logic [IR_W-1:0] INS_DPACC  = 4'b1010;
  localparam logic [IR_W-1:0] INS_APACC  = 4'b1011;
  localparam logic [IR_W-1:0] INS_ABORT  = 4'b1000;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    DR_BYP, DR_ID, DR_DP, DR_AP, DR_ABT
  } dr_sel_e;

endpackage

// File: rtl/dap_tap_fsm.sv
module dap_tap_fsm
  import dap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

  // R1
  // A high TMS keeps the controller parked in Test-Logic-Reset.
  tlr_hold_chk: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET && tms) |=> (state == ST_RESET));

endmodule

// File: rtl/dap_ir.sv
module dap_ir
  import dap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_lsb,
  output dr_sel_e    sel
);

  logic [IR_W-1:0] ir_q;
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_q  <= INS_IDENT;
      ir_sh <= '0;
    end else begin
      unique case (state)
        ST_RESET:  ir_q  <= INS_IDENT;
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UP_IR:  ir_q  <= ir_sh;
        default:   ;
      endcase
    end
  end

  assign ir_lsb = ir_sh[0];

  always_comb begin
    unique case (ir_q)
      INS_IDENT: sel = DR_ID;
      INS_DPACC: sel = DR_DP;
      INS_APACC: sel = DR_AP;
      INS_ABORT: sel = DR_ABT;
      default:   sel = DR_BYP;
    endcase
  end

  // R4
  // The instruction changes only through Update-IR or Test-Logic-Reset.
  ir_hold_chk: assert property (@(posedge tck) disable iff (rst)
    !(state == ST_UP_IR || state == ST_RESET) |=> $stable(ir_q));

endmodule

// File: rtl/dap_dr.sv
module dap_dr
  import dap_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ACK_W    = 3,
  parameter int          ADDR_W   = 2,
  parameter logic [31:0] ID_VALUE = 32'h3BA0_0477
) (
  input  logic              tck,
  input  logic              rst,
  input  tap_state_e        state,
  input  dr_sel_e           sel,
  input  logic              tdi,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [ACK_W-1:0]  rsp_ack,
  output logic              dr_lsb,
  output logic              req_valid,
  output logic              req_ap,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_rnw,
  output logic [DATA_W-1:0] req_wdata,
  output logic              abort_pulse
);

  // The inward format reuses the acknowledge field for address plus RnW,
  // so ADDR_W + 1 is expected to equal ACK_W.
  localparam int SR_W  = DATA_W + ACK_W;
  localparam int IDX_W = $clog2(SR_W);

  logic [SR_W-1:0]  sr;
  logic [SR_W-1:0]  sr_shift;
  logic [IDX_W-1:0] top_idx;
  logic             is_acc;

  assign is_acc = (sel == DR_DP) || (sel == DR_AP);

  always_comb begin
    unique case (sel)
      DR_BYP:  top_idx = '0;
      DR_ID:   top_idx = IDX_W'(32 - 1);
      default: top_idx = IDX_W'(SR_W - 1);
    endcase
    sr_shift          = sr >> 1;
    sr_shift[top_idx] = tdi;
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      sr <= '0;
    end else if (state == ST_CAP_DR) begin
      unique case (sel)
        DR_ID:        sr <= SR_W'(ID_VALUE);
        DR_DP, DR_AP: sr <= {rsp_data, rsp_ack};
        default:      sr <= '0;
      endcase
    end else if (state == ST_SH_DR) begin
      sr <= sr_shift;
    end
  end

  assign dr_lsb = sr[0];

  always_ff @(posedge tck) begin
    if (rst) begin
      req_valid   <= 1'b0;
      abort_pulse <= 1'b0;
      req_ap      <= 1'b0;
      req_addr    <= '0;
      req_rnw     <= 1'b0;
      req_wdata   <= '0;
    end else begin
      req_valid   <= (state == ST_UP_DR) && is_acc;
      abort_pulse <= (state == ST_UP_DR) && (sel == DR_ABT) && sr[ACK_W];
      if ((state == ST_UP_DR) && is_acc) begin
        req_ap    <= (sel == DR_AP);
        req_addr  <= sr[ADDR_W:1];
        req_rnw   <= sr[0];
        req_wdata <= sr[SR_W-1:ACK_W];
      end
    end
  end

  // R6
  req_pulse_chk: assert property (@(posedge tck) disable iff (rst)
    req_valid |=> !req_valid);

  // R7
  abort_pulse_chk: assert property (@(posedge tck) disable iff (rst)
    abort_pulse |=> !abort_pulse);

  // R7
  abort_excl_chk: assert property (@(posedge tck) disable iff (rst)
    $onehot0({req_valid, abort_pulse}));

endmodule

// File: rtl/jtag_dap_top.sv
module jtag_dap_top
  import dap_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ACK_W    = 3,
  parameter int          ADDR_W   = 2,
  parameter logic [31:0] ID_VALUE = 32'h3BA0_0477
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [ACK_W-1:0]  rsp_ack,
  output logic              req_valid,
  output logic              req_ap,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_rnw,
  output logic [DATA_W-1:0] req_wdata,
  output logic              abort_pulse
);

  logic       rst;
  tap_state_e state;
  dr_sel_e    sel;
  logic       ir_lsb;
  logic       dr_lsb;

  assign rst = ~trst_n;

  dap_tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  dap_ir u_ir (
    .tck    (tck),
    .rst    (rst),
    .state  (state),
    .tdi    (tdi),
    .ir_lsb (ir_lsb),
    .sel    (sel)
  );

  dap_dr #(
    .DATA_W   (DATA_W),
    .ACK_W    (ACK_W),
    .ADDR_W   (ADDR_W),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck         (tck),
    .rst         (rst),
    .state       (state),
    .sel         (sel),
    .tdi         (tdi),
    .rsp_data    (rsp_data),
    .rsp_ack     (rsp_ack),
    .dr_lsb      (dr_lsb),
    .req_valid   (req_valid),
    .req_ap      (req_ap),
    .req_addr    (req_addr),
    .req_rnw     (req_rnw),
    .req_wdata   (req_wdata),
    .abort_pulse (abort_pulse)
  );

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SH_DR) || (state == ST_SH_IR);
      unique case (state)
        ST_SH_IR: tdo <= ir_lsb;
        ST_SH_DR: tdo <= dr_lsb;
        default:  tdo <= 1'b0;
      endcase
    end
  end

  // R8
  // The falling-edge enable matches the state held since the previous rise.
  oe_window_chk: assert property (@(posedge tck) disable iff (rst)
    tdo_oe == ((state == ST_SH_DR) || (state == ST_SH_IR)));

endmodule

// File: tb/jtag_dap_top_tb.sv
module jtag_dap_top_tb;

  localparam int CLK_PERIOD = 20;
  localparam int NB = 40;
  localparam logic [31:0] IDV = 32'h3BA0_0477;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        tdo, tdo_oe;
  logic [31:0] rsp_data = '0;
  logic [2:0]  rsp_ack = '0;
  logic        req_valid, req_ap, req_rnw, abort_pulse;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;

  int checks = 0;
  int errors = 0;
  int oe_bad = 0;
  int edge_bad = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  jtag_dap_top u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .rsp_data(rsp_data), .rsp_ack(rsp_ack), .req_valid(req_valid), .req_ap(req_ap),
    .req_addr(req_addr), .req_rnw(req_rnw), .req_wdata(req_wdata),
    .abort_pulse(abort_pulse)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One TCK cycle starting just after a falling edge.
  task automatic clk(input logic m, input logic d, input logic oe_exp, output logic o);
    tms = m;
    tdi = d;
    o   = tdo;
    if (tdo_oe !== oe_exp) oe_bad++;
    @(posedge tck);
    #1;
    if (tdo !== o) edge_bad++;
    @(negedge tck);
    #1;
  endtask

  task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
    logic o;
    clk(1, 0, 0, o);
    clk(1, 0, 0, o);
    clk(0, 0, 0, o);
    clk(0, 0, 0, o);
    for (int i = 0; i < 4; i++) begin
      clk(i == 3, code[i], 1, o);
      cap[i] = o;
    end
    clk(1, 0, 0, o);
    clk(0, 0, 0, o);
  endtask

  task automatic scan_dr(input logic [NB-1:0] din, output logic [NB-1:0] dout);
    logic o;
    clk(1, 0, 0, o);
    clk(0, 0, 0, o);
    clk(0, 0, 0, o);
    for (int i = 0; i < NB; i++) begin
      clk(i == NB-1, din[i], 1, o);
      dout[i] = o;
    end
    clk(1, 0, 0, o);
    clk(0, 0, 0, o);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NB-1:0] din, dout, exp_out;
    logic [3:0]    cap;
    logic          o;
    @(negedge tck);
    #1;
    for (int i = 0; i < 3; i++) clk(1, 0, 0, o);
    trst_n = 1'b1;

    // R1 reset state
    chk(tdo_oe == 0 && req_valid == 0 && abort_pulse == 0, "R1",
        {tdo_oe, req_valid, abort_pulse}, 0);
    clk(0, 0, 0, o);
    scan_dr('0, dout);
    chk(dout[31:0] == IDV, "R1", dout[31:0], IDV);
    // R3 identification word and its fields
    chk(dout[31:28] == 4'h3 && dout[27:12] == 16'hBA00 && dout[11:1] == 11'h23B
        && dout[0] == 1'b1, "R3", dout[31:0], IDV);

    // R1 five TMS-high clocks return to identification
    scan_ir(4'b1111, cap);
    for (int i = 0; i < 5; i++) clk(1, 0, 0, o);
    clk(0, 0, 0, o);
    scan_dr('0, dout);
    chk(dout[31:0] == IDV, "R1", dout[31:0], IDV);

    // R1 trst mid-session
    scan_ir(4'b1010, cap);
    trst_n = 1'b0;
    clk(0, 0, 0, o);
    trst_n = 1'b1;
    clk(0, 0, 0, o);
    scan_dr('0, dout);
    chk(dout[31:0] == IDV, "R1", dout[31:0], IDV);

    // Sweep every instruction code with two patterns (R2 R4 R5 R6 R7)
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 16; c++) begin
        int            len;
        logic [NB-1:0] capv;
        logic [31:0]   wd;
        logic          is_acc, is_abt;
        wd       = (pass == 0 ? 32'h2B3C_4D5F : 32'hF0E1_D2C4) ^ {c[3:0], 28'h0};
        din      = {wd, (pass == 0 ? 8'h59 : 8'hA6)};
        rsp_data = {16'hC0DE, 8'(c), 8'(pass)};
        rsp_ack  = c[2:0];
        is_acc   = (c == 4'b1010) || (c == 4'b1011);
        is_abt   = (c == 4'b1000);
        if (c == 4'b1110) begin
          len = 32; capv = NB'(IDV);
        end else if (is_acc) begin
          len = 35; capv = NB'({rsp_data, rsp_ack});
        end else if (is_abt) begin
          len = 35; capv = '0;
        end else begin
          len = 1; capv = '0;
        end
        for (int k = 0; k < NB; k++)
          exp_out[k] = (k < len) ? capv[k] : din[k-len];

        scan_ir(4'(c), cap);
        // R2
        chk(cap == 4'b0001, "R2", cap, 4'b0001);
        scan_dr(din, dout);
        if (is_acc)
          chk(dout == exp_out, "R5", dout, exp_out);
        else
          chk(dout == exp_out, "R4", dout, exp_out);
        // R6
        chk(req_valid == is_acc, "R6", req_valid, is_acc);
        if (is_acc) begin
          chk(req_wdata == din[39:8] && req_addr == din[7:6] && req_rnw == din[5]
              && req_ap == (c == 4'b1011), "R6",
              {req_ap, req_addr, req_rnw, req_wdata},
              {(c == 4'b1011), din[7:6], din[5], din[39:8]});
        end
        // R7
        chk(abort_pulse == (is_abt && din[8]), "R7", abort_pulse, is_abt && din[8]);
        clk(0, 0, 0, o);
        // R6 R7 single-cycle strobes
        chk(req_valid == 0 && abort_pulse == 0, "R6", {req_valid, abort_pulse}, 0);
      end
    end

    // R8
    chk(oe_bad == 0, "R8", oe_bad, 0);
    chk(edge_bad == 0, "R8", edge_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule